// File: doc/BRIEF.md
# Buffer-Driven Framed Block Generator

This block turns the contents of a small waveform buffer into a train of framed streaming blocks. Each output sample carries valid, start-of-block, end-of-block and sync flags. A four-state sequencer (`ST_IDLE`, `ST_READ`, `ST_GAP`, `ST_HOLD`) issues one buffer read per cycle while it streams a block. The buffer answers one cycle later, and a framer re-times the block flags so that they meet the returned data in a single output register stage. The read address moves through a window bounded by a low and a high address. It keeps advancing from one block to the next rather than restarting, and it folds back to the low address when it passes the high one.

Generation starts only when the enable control is set and a one-cycle enable-sync pulse arrives. After that, blocks of `ctrl_spp` samples follow one another, separated by `ctrl_gap` idle cycles. A downstream `xon` flag can hold off the next block. It is only looked at when a new block would begin, so a block that has started always runs to its end. Clearing enable lets the current block and its gap finish, and the sequencer then returns to idle. Two build options are available. The first replaces the external buffer with a stand-in that returns the read address as data. The second stretches sync over a whole block instead of marking only its first sample.

State transitions: `ST_IDLE`→`ST_READ` when enable and enable-sync are both high. In `ST_READ`, at the last sample, the sequencer goes to `ST_GAP` if the gap is non-zero. Otherwise it takes the boundary decision. The boundary decision goes to `ST_READ` if enable and xon are high, to `ST_HOLD` if enable is high and xon is low, and to `ST_IDLE` if enable is low. `ST_GAP`→boundary decision after `ctrl_gap` cycles. `ST_HOLD`→`ST_READ` once xon rises, or →`ST_IDLE` if enable drops.

Top module: `wave_block_gen`

## Requirements
- R1: While reset is applied and right after it, `buf_rden`, `out_valid`, `out_sop`, `out_eop`, `out_sync` and `out_data` are all zero.
- R2: From idle, no read and no output happens until the edge at which `ctrl_enable` and `en_sync` are both high. An `en_sync` pulse while blocks are running has no effect on the output.
- R3: A block is `ctrl_spp` (at least 1) valid samples on consecutive cycles. `out_sop` is high on the first of them and `out_eop` on the last. The first block after a start reads address `ctrl_low`.
- R4: Each read address is the previous one plus one, or `ctrl_low` when the previous address was at or above `ctrl_high`. This stepping carries on across block boundaries. With the buffer fitted, `out_data` is the word the buffer returned for that address.
- R5: A read requested in the cycle after edge E is presented on the outputs after edge E+2: one cycle of buffer latency plus one output register.
- R6: While enable and xon stay high, exactly `ctrl_gap` idle cycles separate one block's eop from the next block's sop (0 means back to back).
- R7: xon is sampled only when a new block would begin. If it is low then, no block starts, and the first read of the next block follows the edge at which xon is seen high again. Dropping xon inside a block does not shorten that block.
- R8: The first block after a start carries sync, and so does every `ctrl_bps`-th block after it (0 or 1 means every block). In the default mode `out_sync` is high only on the sop sample of such a block.
- R9: With `BLK_SYNC=1`, `out_sync` is high on every sample of a sync block, from sop through eop.
- R10: With `USE_RAM=0`, `out_data` is the read address zero-extended to `DAT_W` bits, with the same latency as R5.
- R11: Clearing `ctrl_enable` lets the running block and its gap complete, and then no further block starts. Setting enable again without an `en_sync` pulse starts nothing. A fresh pulse restarts at `ctrl_low` with a sync block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Streaming clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_enable | input | 1 | Generation enable |
| ctrl_spp | input | SPP_W | Samples per block (at least 1) |
| ctrl_low | input | ADDR_W | Lowest buffer address of the window |
| ctrl_high | input | ADDR_W | Highest buffer address of the window |
| ctrl_bps | input | BPS_W | Blocks per sync period |
| ctrl_gap | input | GAP_W | Idle cycles between blocks |
| en_sync | input | 1 | Start pulse, qualified by ctrl_enable |
| xon | input | 1 | Downstream permission, checked per block |
| buf_addr | output | ADDR_W | Buffer read address |
| buf_rden | output | 1 | Buffer read strobe |
| buf_rddata | input | DAT_W | Buffer read data (one-cycle latency) |
| buf_rdval | input | 1 | Buffer read-data valid |
| out_valid | output | 1 | Output sample valid |
| out_sop | output | 1 | First sample of a block |
| out_eop | output | 1 | Last sample of a block |
| out_sync | output | 1 | Sync marker |
| out_data | output | DAT_W | Output sample |

## Verification
Every expected sample is stamped with the cycle it is due in. That cycle is the edge that started its block plus two, plus its position in the block. The block start edge is the `en_sync` edge, the previous start plus `ctrl_spp + ctrl_gap`, or the edge at which xon is seen high again after a hold. The monitor samples on falling edges and compares the cycle, data, sop, eop and sync of each valid sample with the head of its queue. A sample that arrives early, arrives late or is not expected therefore fails at once. Idle windows (before a start, during a hold, after enable drops) are checked by counting output samples across them. Two instances share the stimulus: one has a modelled buffer and pulse sync, the other has the address stand-in and block-long sync.

// File: rtl/wbg_pkg.sv
package wbg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_GAP,
        ST_HOLD
    } wbg_state_e;

    typedef struct packed {
        logic sop;
        logic eop;
        logic sync_blk;
    } wbg_tag_t;

endpackage

// File: rtl/wbg_sequencer.sv
module wbg_sequencer
    import wbg_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int SPP_W  = 16,
    parameter int BPS_W  = 16,
    parameter int GAP_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_enable,
    input  logic [SPP_W-1:0]  ctrl_spp,
    input  logic [ADDR_W-1:0] ctrl_low,
    input  logic [ADDR_W-1:0] ctrl_high,
    input  logic [BPS_W-1:0]  ctrl_bps,
    input  logic [GAP_W-1:0]  ctrl_gap,
    input  logic              en_sync,
    input  logic              xon,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output wbg_tag_t          rd_tag
);

    localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);
    localparam logic [SPP_W-1:0]  ONE_S = SPP_W'(1);
    localparam logic [GAP_W-1:0]  ONE_G = GAP_W'(1);
    localparam logic [BPS_W:0]    ONE_B = (BPS_W+1)'(1);

    wbg_state_e        state_q, state_d, boundary_st;
    logic [ADDR_W-1:0] addr_q, addr_nxt;
    logic [SPP_W-1:0]  smp_q;
    logic [GAP_W-1:0]  gap_q;
    logic [BPS_W-1:0]  blk_q, blk_nxt;
    logic [BPS_W:0]    blk_inc;
    logic              smp_last, gap_last, gap_zero, start_go;

    assign smp_last = (smp_q == (ctrl_spp - ONE_S));
    assign gap_last = (gap_q == (ctrl_gap - ONE_G));
    assign gap_zero = (ctrl_gap == '0);
    assign start_go = ctrl_enable & en_sync;

    // window stepping with fold back to the low address
    assign addr_nxt = (addr_q >= ctrl_high) ? ctrl_low : (addr_q + ONE_A);

    // sync period counter
    assign blk_inc = {1'b0, blk_q} + ONE_B;
    assign blk_nxt = (blk_inc >= {1'b0, ctrl_bps}) ? '0 : blk_inc[BPS_W-1:0];

    // decision taken whenever a new block could begin
    always_comb begin
        if (!ctrl_enable) begin
            boundary_st = ST_IDLE;
        end else if (xon) begin
            boundary_st = ST_READ;
        end else begin
            boundary_st = ST_HOLD;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_go) state_d = ST_READ;
            ST_READ: begin
                if (smp_last) begin
                    state_d = gap_zero ? boundary_st : ST_GAP;
                end
            end
            ST_GAP:  if (gap_last) state_d = boundary_st;
            ST_HOLD: begin
                if (!ctrl_enable) begin
                    state_d = ST_IDLE;
                end else if (xon) begin
                    state_d = ST_READ;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // counters and address
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            smp_q  <= '0;
            gap_q  <= '0;
            blk_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    addr_q <= ctrl_low;
                    smp_q  <= '0;
                    gap_q  <= '0;
                    blk_q  <= '0;
                end
                ST_READ: begin
                    addr_q <= addr_nxt;
                    if (smp_last) begin
                        smp_q <= '0;
                        gap_q <= '0;
                        blk_q <= blk_nxt;
                    end else begin
                        smp_q <= smp_q + ONE_S;
                    end
                end
                ST_GAP:  gap_q <= gap_q + ONE_G;
                ST_HOLD: gap_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        rd_req          = (state_q == ST_READ);
        rd_addr         = addr_q;
        rd_tag.sop      = (smp_q == '0);
        rd_tag.eop      = smp_last;
        rd_tag.sync_blk = (blk_q == '0);
    end

    // R2: idle persists until enable and the start pulse coincide
    p_idle_wait_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !start_go) |=> (state_q == ST_IDLE));

    // R3: a start reads the low address first
    p_start_low_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && start_go) |=> (rd_req && rd_addr == $past(ctrl_low)));

    // R7: a started block is never cut short
    p_block_whole_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_READ && !smp_last) |=> (state_q == ST_READ));

endmodule

// File: rtl/wbg_buf_port.sv
module wbg_buf_port #(
    parameter bit USE_RAM = 1'b1,
    parameter int ADDR_W  = 7,
    parameter int DAT_W   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DAT_W-1:0]  ext_data,
    input  logic              ext_valid,
    output logic [DAT_W-1:0]  data,
    output logic              valid
);

    generate
        if (USE_RAM) begin : g_ram
            assign data  = ext_data;
            assign valid = ext_valid;

            // R5: the fitted buffer answers exactly one cycle after a request
            p_buf_lat_r5: assert property (@(posedge clk) disable iff (rst)
                ext_valid |-> $past(req));
        end else begin : g_standin
            always_ff @(posedge clk) begin
                if (rst) begin
                    valid <= 1'b0;
                    data  <= '0;
                end else begin
                    valid <= req;
                    data  <= DAT_W'(addr);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/wbg_framer.sv
module wbg_framer
    import wbg_pkg::*;
#(
    parameter int DAT_W    = 32,
    parameter bit BLK_SYNC = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  wbg_tag_t         tag,
    input  logic [DAT_W-1:0] bdata,
    input  logic             bvalid,
    output logic             out_valid,
    output logic             out_sop,
    output logic             out_eop,
    output logic             out_sync,
    output logic [DAT_W-1:0] out_data
);

    wbg_tag_t tag_q;
    logic     sync_d;

    // align the flags with the one-cycle buffer latency
    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q <= '0;
        end else begin
            tag_q <= req ? tag : '0;
        end
    end

    generate
        if (BLK_SYNC) begin : g_blk_sync
            assign sync_d = bvalid & tag_q.sync_blk;
        end else begin : g_pulse_sync
            assign sync_d = bvalid & tag_q.sync_blk & tag_q.sop;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
            out_sync  <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= bvalid;
            out_sop   <= bvalid & tag_q.sop;
            out_eop   <= bvalid & tag_q.eop;
            out_sync  <= sync_d;
            out_data  <= bvalid ? bdata : '0;
        end
    end

    // R3: inside a block the samples arrive on consecutive cycles
    p_no_hole_r3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_sop) |-> $past(out_valid));

    generate
        if (BLK_SYNC) begin : g_chk_blk
            // R9: sync level is constant across a block
            p_sync_span_r9: assert property (@(posedge clk) disable iff (rst)
                (out_valid && !out_sop) |-> (out_sync == $past(out_sync)));
        end
    endgenerate

endmodule

// File: rtl/wave_block_gen.sv
module wave_block_gen
    import wbg_pkg::*;
#(
    parameter int ADDR_W   = 7,
    parameter int DAT_W    = 32,
    parameter int SPP_W    = 16,
    parameter int BPS_W    = 16,
    parameter int GAP_W    = 16,
    parameter bit USE_RAM  = 1'b1,
    parameter bit BLK_SYNC = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_enable,
    input  logic [SPP_W-1:0]  ctrl_spp,
    input  logic [ADDR_W-1:0] ctrl_low,
    input  logic [ADDR_W-1:0] ctrl_high,
    input  logic [BPS_W-1:0]  ctrl_bps,
    input  logic [GAP_W-1:0]  ctrl_gap,
    input  logic              en_sync,
    input  logic              xon,
    output logic [ADDR_W-1:0] buf_addr,
    output logic              buf_rden,
    input  logic [DAT_W-1:0]  buf_rddata,
    input  logic              buf_rdval,
    output logic              out_valid,
    output logic              out_sop,
    output logic              out_eop,
    output logic              out_sync,
    output logic [DAT_W-1:0]  out_data
);

    wbg_tag_t         req_tag;
    logic [DAT_W-1:0] rd_data;
    logic             rd_valid;

    wbg_sequencer #(
        .ADDR_W (ADDR_W),
        .SPP_W  (SPP_W),
        .BPS_W  (BPS_W),
        .GAP_W  (GAP_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .ctrl_enable (ctrl_enable),
        .ctrl_spp    (ctrl_spp),
        .ctrl_low    (ctrl_low),
        .ctrl_high   (ctrl_high),
        .ctrl_bps    (ctrl_bps),
        .ctrl_gap    (ctrl_gap),
        .en_sync     (en_sync),
        .xon         (xon),
        .rd_req      (buf_rden),
        .rd_addr     (buf_addr),
        .rd_tag      (req_tag)
    );

    wbg_buf_port #(
        .USE_RAM (USE_RAM),
        .ADDR_W  (ADDR_W),
        .DAT_W   (DAT_W)
    ) u_port (
        .clk       (clk),
        .rst       (rst),
        .req       (buf_rden),
        .addr      (buf_addr),
        .ext_data  (buf_rddata),
        .ext_valid (buf_rdval),
        .data      (rd_data),
        .valid     (rd_valid)
    );

    wbg_framer #(
        .DAT_W    (DAT_W),
        .BLK_SYNC (BLK_SYNC)
    ) u_frm (
        .clk       (clk),
        .rst       (rst),
        .req       (buf_rden),
        .tag       (req_tag),
        .bdata     (rd_data),
        .bvalid    (rd_valid),
        .out_valid (out_valid),
        .out_sop   (out_sop),
        .out_eop   (out_eop),
        .out_sync  (out_sync),
        .out_data  (out_data)
    );

    // R5: every output sample traces back to a read two edges earlier
    p_out_lat_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(buf_rden, 2));

endmodule

// File: tb/wave_block_gen_tb.sv
module wave_block_gen_tb;

    localparam int ADDR_W = 7;
    localparam int DAT_W  = 32;
    localparam int SPP_W  = 8;
    localparam int BPS_W  = 8;
    localparam int GAP_W  = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst = 1'b1;
    logic              ctrl_enable = 1'b0;
    logic [SPP_W-1:0]  ctrl_spp = '0;
    logic [ADDR_W-1:0] ctrl_low = '0;
    logic [ADDR_W-1:0] ctrl_high = '0;
    logic [BPS_W-1:0]  ctrl_bps = '0;
    logic [GAP_W-1:0]  ctrl_gap = '0;
    logic              en_sync = 1'b0;
    logic              xon = 1'b1;

    logic [ADDR_W-1:0] a_addr, b_addr;
    logic              a_rden, b_rden;
    logic              a_valid, a_sop, a_eop, a_sync;
    logic              b_valid, b_sop, b_eop, b_sync;
    logic [DAT_W-1:0]  a_data, b_data;
    logic [DAT_W-1:0]  ram_rddata = '0;
    logic              ram_rdval = 1'b0;

    function automatic logic [31:0] ram_val(input int a);
        return 32'h5A00_0000 | (a * 13);
    endfunction

    // buffer model, one-cycle read latency
    always @(posedge clk) begin
        ram_rdval  <= a_rden;
        ram_rddata <= ram_val(int'(a_addr));
    end

    wave_block_gen #(
        .ADDR_W(ADDR_W), .DAT_W(DAT_W), .SPP_W(SPP_W), .BPS_W(BPS_W), .GAP_W(GAP_W),
        .USE_RAM(1'b1), .BLK_SYNC(1'b0)
    ) u_dut (
        .clk(clk), .rst(rst), .ctrl_enable(ctrl_enable), .ctrl_spp(ctrl_spp),
        .ctrl_low(ctrl_low), .ctrl_high(ctrl_high), .ctrl_bps(ctrl_bps), .ctrl_gap(ctrl_gap),
        .en_sync(en_sync), .xon(xon), .buf_addr(a_addr), .buf_rden(a_rden),
        .buf_rddata(ram_rddata), .buf_rdval(ram_rdval), .out_valid(a_valid),
        .out_sop(a_sop), .out_eop(a_eop), .out_sync(a_sync), .out_data(a_data)
    );

    wave_block_gen #(
        .ADDR_W(ADDR_W), .DAT_W(DAT_W), .SPP_W(SPP_W), .BPS_W(BPS_W), .GAP_W(GAP_W),
        .USE_RAM(1'b0), .BLK_SYNC(1'b1)
    ) u_alt (
        .clk(clk), .rst(rst), .ctrl_enable(ctrl_enable), .ctrl_spp(ctrl_spp),
        .ctrl_low(ctrl_low), .ctrl_high(ctrl_high), .ctrl_bps(ctrl_bps), .ctrl_gap(ctrl_gap),
        .en_sync(en_sync), .xon(xon), .buf_addr(b_addr), .buf_rden(b_rden),
        .buf_rddata('0), .buf_rdval(1'b0), .out_valid(b_valid),
        .out_sop(b_sop), .out_eop(b_eop), .out_sync(b_sync), .out_data(b_data)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int t;
        int addr;
        bit sop;
        bit eop;
        bit sb;
    } exp_t;

    exp_t qa[$];
    exp_t qb[$];
    exp_t ea, eb;
    int n_chk = 0, n_fail = 0;
    int seen_a = 0, seen_b = 0, n_pushed = 0;
    int m_addr = 0, m_blk = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_start();
        m_addr = int'(ctrl_low);
        m_blk  = 0;
    endtask

    // driver side of the scoreboard: expected samples of one block
    task automatic push_block(input int s);
        exp_t e;
        for (int k = 0; k < int'(ctrl_spp); k++) begin
            e.t    = s + 2 + k;
            e.addr = m_addr;
            e.sop  = (k == 0);
            e.eop  = (k == int'(ctrl_spp) - 1);
            e.sb   = (m_blk == 0);
            qa.push_back(e);
            qb.push_back(e);
            n_pushed++;
            m_addr = (m_addr >= int'(ctrl_high)) ? int'(ctrl_low) : m_addr + 1;
        end
        m_blk = (m_blk + 1 >= int'(ctrl_bps)) ? 0 : m_blk + 1;
    endtask

    task automatic pulse_sync(output int e);
        @(negedge clk);
        en_sync = 1'b1;
        @(posedge clk);
        #1;
        e = cyc;
        en_sync = 1'b0;
    endtask

    task automatic wait_cyc(input int target);
        while (cyc < target) @(negedge clk);
    endtask

    // monitor side of the scoreboard
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (a_valid) begin
                seen_a++;
                if (qa.size() == 0) begin
                    check(1'b0, "R2", "unexpected sample on A at cycle", cyc, -1);
                end else begin
                    ea = qa.pop_front();
                    check(cyc == ea.t, "R5/R6", "A sample cycle", cyc, ea.t);
                    check(a_data == ram_val(ea.addr), "R4", "A data", a_data, ram_val(ea.addr));
                    check(a_sop == ea.sop && a_eop == ea.eop, "R3", "A sop/eop",
                          {a_sop, a_eop}, {ea.sop, ea.eop});
                    check(a_sync == (ea.sb && ea.sop), "R8", "A sync", a_sync, ea.sb && ea.sop);
                end
            end
            if (b_valid) begin
                seen_b++;
                if (qb.size() == 0) begin
                    check(1'b0, "R2", "unexpected sample on B at cycle", cyc, -1);
                end else begin
                    eb = qb.pop_front();
                    check(cyc == eb.t, "R5", "B sample cycle", cyc, eb.t);
                    check(b_data == DAT_W'(eb.addr), "R10", "B data", b_data, eb.addr);
                    check(b_sop == eb.sop && b_eop == eb.eop, "R3", "B sop/eop",
                          {b_sop, b_eop}, {eb.sop, eb.eop});
                    check(b_sync == eb.sb, "R9", "B sync", b_sync, eb.sb);
                end
            end
        end
    end

    task automatic finish_up();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 20000);
        finish_up();
    end

    initial begin
        int e0, e1, x, snap;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check({a_rden, a_valid, a_sop, a_eop, a_sync} == 5'b0 && a_data == '0, "R1",
              "A quiet in reset", {a_rden, a_valid, a_sop, a_eop, a_sync}, 0);
        check({b_rden, b_valid, b_sop, b_eop, b_sync} == 5'b0 && b_data == '0, "R1",
              "B quiet in reset", {b_rden, b_valid, b_sop, b_eop, b_sync}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(a_valid == 1'b0 && a_rden == 1'b0, "R1", "A quiet after reset", a_valid, 0);

        // R2: enabled but no start pulse
        ctrl_enable = 1'b1;
        ctrl_spp = 8; ctrl_gap = 3; ctrl_bps = 3;
        ctrl_low = 0; ctrl_high = 127;
        repeat (20) @(negedge clk);
        check(seen_a == 0 && seen_b == 0, "R2", "samples without start pulse", seen_a + seen_b, 0);

        // main run: 6 blocks with gap 3, sync every 3rd block
        model_start();
        pulse_sync(e0);
        for (int b = 0; b < 6; b++) push_block(e0 + b * 11);
        wait_cyc(e0 + 14);
        en_sync = 1'b1;          // R2: pulse while running has no effect
        @(negedge clk);
        en_sync = 1'b0;
        wait_cyc(e0 + 5 * 11 + 1);
        ctrl_enable = 1'b0;      // R11: stop after block 5
        repeat (30) @(negedge clk);
        check(qa.size() == 0 && qb.size() == 0, "R11", "blocks pending after stop",
              qa.size() + qb.size(), 0);
        check(seen_a == 48, "R11", "A samples of first run", seen_a, 48);

        // R11: re-enable without pulse starts nothing
        snap = seen_a;
        ctrl_enable = 1'b1;
        repeat (20) @(negedge clk);
        check(seen_a == snap, "R11", "samples after re-enable without pulse", seen_a - snap, 0);

        // window wrap, back-to-back blocks, hold by xon
        ctrl_low = 10; ctrl_high = 14; ctrl_spp = 4; ctrl_gap = 0; ctrl_bps = 2;
        @(negedge clk);
        model_start();
        pulse_sync(e1);
        for (int b = 0; b < 4; b++) push_block(e1 + b * 4);
        wait_cyc(e1 + 13);
        xon = 1'b0;              // R7: drop during block 3
        wait_cyc(e1 + 20);
        snap = seen_a;
        wait_cyc(e1 + 30);
        check(seen_a == snap, "R7", "samples while xon low", seen_a - snap, 0);
        check(qa.size() == 0, "R7", "block 3 completed despite xon drop", qa.size(), 0);
        xon = 1'b1;
        @(posedge clk);
        #1;
        x = cyc;
        push_block(x);
        push_block(x + 4);
        wait_cyc(x + 5);
        ctrl_enable = 1'b0;
        repeat (20) @(negedge clk);
        check(qa.size() == 0 && qb.size() == 0, "R11", "pending after second stop",
              qa.size() + qb.size(), 0);
        check(seen_a == n_pushed && seen_b == n_pushed, "R3", "total samples",
              seen_a + seen_b, 2 * n_pushed);
        finish_up();
    end

endmodule